// File: doc/BRIEF.md
# Fixed Off-Time Current-Chopping Timer

This block sequences the current chopping of one motor bridge. While the bridge is driving, a trip from the current comparator starts an off period. The off period has a programmed length. It opens with a programmable fast-decay portion and finishes in slow decay. After the off period a blanking window masks the comparator while the drive switches back on. Only then may a further trip be honoured.

All counting is done in ticks of a master oscillator. The tick is a single-cycle enable in the system clock domain. Codes set the lengths:

- Off length: 8N+7 ticks, where N is the 5-bit off code.
- Fast-decay length: 8M+7 ticks, where M is the 4-bit fast code.
- Blanking window: 4, 6, 8 or 12 ticks, chosen by the 2-bit blank code.

A slow-mode input drops the fast portion. A change of the phase input restarts blanking. Disabling the bridge, or giving it a zero current code, parks the timer with every output low.

Top module: `pwm_offtime_timer`

## Requirements
- R1: While rstN is low all four state outputs (onPhase, fastDecay, slowDecay, blanking) are 0. After reset the outputs stay 0 while the bridge is inactive.
- R2: A trip sampled while onPhase=1 and blanking=0 starts an off period on the next cycle. The off period lasts exactly 8N+7 ticks, where N = offCode (0..31).
- R3: With slowMode=0 the off period starts in fast decay (fastDecay=1) for 8M+7 ticks, where M = fastCode (0..15). The remaining ticks of the off period are spent in slow decay (slowDecay=1).
- R4: When 8M+7 is at least 8N+7, the whole off period is spent in fast decay and no slow-decay tick occurs.
- R5: With slowMode=1 the whole off period is spent in slow decay and fastDecay stays 0.
- R6: When the off period ends, blanking=1 and onPhase=1 for a window whose length in ticks is set by blankCode: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 12. Trips during this window are ignored.
- R7: Trips arriving during an off period are ignored. They do not restart or lengthen it.
- R8: A change of the phase input while driving or blanking restarts the blanking window from zero, so a full window follows. While driving, a phase change takes priority over a simultaneous trip.
- R9: When enable=0 or curCode=0, all outputs are 0 from the next cycle and trips are ignored. On re-activation the timer enters the blanking window first.
- R10: Counters advance only on cycles with oscTick=1. Without a tick, an off period or blanking window never ends.
- R11: At most one of onPhase, fastDecay and slowDecay is 1 at a time, and blanking=1 only together with onPhase=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | Single-cycle master oscillator tick |
| enable | input | 1 | Bridge enable |
| curCode | input | 6 | Current level code; zero disables the bridge |
| trip | input | 1 | Current comparator trip |
| phase | input | 1 | Bridge current direction |
| slowMode | input | 1 | 0 = mixed decay, 1 = slow decay only |
| offCode | input | 5 | Off-time code N |
| fastCode | input | 4 | Fast-decay code M |
| blankCode | input | 2 | Blanking window select |
| onPhase | output | 1 | Drive is on (including blanking) |
| fastDecay | output | 1 | Off period, fast-decay portion |
| slowDecay | output | 1 | Off period, slow-decay portion |
| blanking | output | 1 | Comparator is masked |

## Verification
On every cycle, the assertions check the following:
- The outputs are mutually exclusive.
- Outputs go low after deactivation.
- A trip in unmasked drive starts an off period.
- A phase change in drive forces blanking.
- Neither an off period nor a blanking window ends without a tick.

The bench scenarios measure lengths in ticks under random tick density. They show:
- The exact off, fast-decay, slow-decay and blanking lengths for each code.
- That noise trips during the off period and during blanking leave those lengths unchanged.
- The restart of blanking on a phase change.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_OFF,
    ST_BLANK
  } pwmState_t;

  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrobe_t;
endpackage

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
#(
  parameter int OFF_W   = 5,
  parameter int FAST_W  = 4,
  parameter int BLANK_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntStrobe_t         strb,
  input  logic [OFF_W-1:0]   offCode,
  input  logic [FAST_W-1:0]  fastCode,
  input  logic [BLANK_W-1:0] blankCode,
  output logic               offLast,
  output logic               blankLast,
  output logic               inFast
);
  localparam int CNT_W  = ((OFF_W > FAST_W) ? OFF_W : FAST_W) + 3;
  localparam int NBLANK = 1 << BLANK_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] offLen;
  logic [CNT_W-1:0] fastLen;
  logic [CNT_W-1:0] blankLen;
  logic [CNT_W-1:0] blankTable [NBLANK];

  // blanking lengths: 4, 6, 8, 12, then doubling for wider codes
  for (genvar g = 0; g < NBLANK; g++) begin : g_blank
    if (g < 3) begin : g_lin
      assign blankTable[g] = CNT_W'(4 + 2 * g);
    end else begin : g_dbl
      assign blankTable[g] = CNT_W'(12 << (g - 3));
    end
  end

  // (1+code)*8-1 equals the code followed by three ones
  assign offLen   = CNT_W'({offCode, 3'b111});
  assign fastLen  = CNT_W'({fastCode, 3'b111});
  assign blankLen = blankTable[blankCode];

  assign offLast   = (cnt == offLen - CNT_W'(1));
  assign blankLast = (cnt == blankLen - CNT_W'(1));
  assign inFast    = (cnt < fastLen);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clr) begin
      cnt <= '0;
    end else if (strb.inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       active,
  input  logic       trip,
  input  logic       phase,
  input  logic       slowMode,
  input  logic       offLast,
  input  logic       blankLast,
  input  logic       inFast,
  output cntStrobe_t strb,
  output logic       onPhase,
  output logic       fastDecay,
  output logic       slowDecay,
  output logic       blanking
);
  pwmState_t state;
  pwmState_t stateNxt;
  logic      phasePrev;
  logic      phaseChg;

  assign phaseChg = (phase != phasePrev);

  always_comb begin
    stateNxt = state;
    strb     = '0;
    if (!active) begin
      stateNxt = ST_IDLE;
      strb.clr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateNxt = ST_BLANK;
          strb.clr = 1'b1;
        end
        ST_DRIVE: begin
          if (phaseChg) begin
            stateNxt = ST_BLANK;
            strb.clr = 1'b1;
          end else if (trip) begin
            stateNxt = ST_OFF;
            strb.clr = 1'b1;
          end
        end
        ST_OFF: begin
          if (tick && offLast) begin
            stateNxt = ST_BLANK;
            strb.clr = 1'b1;
          end else begin
            strb.inc = tick;
          end
        end
        ST_BLANK: begin
          if (phaseChg) begin
            strb.clr = 1'b1;
          end else if (tick && blankLast) begin
            stateNxt = ST_DRIVE;
            strb.clr = 1'b1;
          end else begin
            strb.inc = tick;
          end
        end
        default: begin
          stateNxt = ST_IDLE;
          strb.clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    phasePrev <= phase;
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  assign onPhase   = (state == ST_DRIVE) || (state == ST_BLANK);
  assign blanking  = (state == ST_BLANK);
  assign fastDecay = (state == ST_OFF) && !slowMode && inFast;
  assign slowDecay = (state == ST_OFF) && !fastDecay;
endmodule

// File: rtl/pwm_offtime_timer.sv
module pwm_offtime_timer
  import pwm_timer_pkg::*;
#(
  parameter int CUR_W   = 6,
  parameter int OFF_W   = 5,
  parameter int FAST_W  = 4,
  parameter int BLANK_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               oscTick,
  input  logic               enable,
  input  logic [CUR_W-1:0]   curCode,
  input  logic               trip,
  input  logic               phase,
  input  logic               slowMode,
  input  logic [OFF_W-1:0]   offCode,
  input  logic [FAST_W-1:0]  fastCode,
  input  logic [BLANK_W-1:0] blankCode,
  output logic               onPhase,
  output logic               fastDecay,
  output logic               slowDecay,
  output logic               blanking
);
  cntStrobe_t strb;
  logic       offLast;
  logic       blankLast;
  logic       inFast;
  logic       active;

  assign active = enable && (curCode != '0);

  pwm_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(oscTick), .active(active), .trip(trip),
    .phase(phase), .slowMode(slowMode), .offLast(offLast),
    .blankLast(blankLast), .inFast(inFast), .strb(strb), .onPhase(onPhase),
    .fastDecay(fastDecay), .slowDecay(slowDecay), .blanking(blanking)
  );

  pwm_timer_dp #(.OFF_W(OFF_W), .FAST_W(FAST_W), .BLANK_W(BLANK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .offCode(offCode),
    .fastCode(fastCode), .blankCode(blankCode), .offLast(offLast),
    .blankLast(blankLast), .inFast(inFast)
  );
endmodule

// File: rtl/pwm_offtime_checker.sv
module pwm_offtime_checker #(
  parameter int CUR_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             oscTick,
  input logic             enable,
  input logic [CUR_W-1:0] curCode,
  input logic             trip,
  input logic             phase,
  input logic             onPhase,
  input logic             fastDecay,
  input logic             slowDecay,
  input logic             blanking
);
  logic active;
  assign active = enable && (curCode != '0);

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({onPhase, fastDecay, slowDecay}) && (!blanking || onPhase));

  p_inactive_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !(onPhase || fastDecay || slowDecay || blanking));

  p_trip_starts_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (active && onPhase && !blanking && trip && phase == $past(phase))
    |=> (fastDecay || slowDecay));

  p_phase_blanks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (active && onPhase && phase != $past(phase)) |=> blanking);

  p_off_needs_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    (active && !oscTick && (fastDecay || slowDecay)) |=> (fastDecay || slowDecay));

  p_blank_needs_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    (active && !oscTick && blanking) |=> blanking);

  p_off_then_blank_r6: assert property (@(posedge clk) disable iff (!rstN)
    (active && (fastDecay || slowDecay)) |=> (fastDecay || slowDecay || blanking));
endmodule

bind pwm_offtime_timer pwm_offtime_checker #(.CUR_W(CUR_W)) u_chk (
  .clk(clk), .rstN(rstN), .oscTick(oscTick), .enable(enable),
  .curCode(curCode), .trip(trip), .phase(phase), .onPhase(onPhase),
  .fastDecay(fastDecay), .slowDecay(slowDecay), .blanking(blanking)
);

// File: tb/tb_pwm_offtime_timer.sv
module tb_pwm_offtime_timer;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0;
  logic enable = 1'b0;
  logic [5:0] curCode = 6'd0;
  logic trip = 1'b0;
  logic phase = 1'b0;
  logic slowMode = 1'b0;
  logic [4:0] offCode = 5'd0;
  logic [3:0] fastCode = 4'd0;
  logic [1:0] blankCode = 2'd0;
  logic onPhase, fastDecay, slowDecay, blanking;

  int errors = 0;
  int checks = 0;
  int tickDiv = 1;
  int cycles = 0;
  bit exclOk = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_offtime_timer dut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .enable(enable),
    .curCode(curCode), .trip(trip), .phase(phase), .slowMode(slowMode),
    .offCode(offCode), .fastCode(fastCode), .blankCode(blankCode),
    .onPhase(onPhase), .fastDecay(fastDecay), .slowDecay(slowDecay),
    .blanking(blanking)
  );

  function automatic int offLenF(int n);
    return 8 * n + 7;
  endfunction

  function automatic int fastPartF(int m, int n, bit slow);
    int f;
    if (slow) return 0;
    f = 8 * m + 7;
    return (f < offLenF(n)) ? f : offLenF(n);
  endfunction

  function automatic int blankLenF(int code);
    case (code)
      0: return 4;
      1: return 6;
      2: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      finishRun();
    end
  end

  // one cycle: advance to the falling edge, pick the tick for the next rising edge
  task automatic step();
    @(negedge clk);
    oscTick = (tickDiv <= 1) ? 1'b1 : ($urandom_range(tickDiv - 1) == 0);
    if (!($countones({onPhase, fastDecay, slowDecay}) <= 1 && (!blanking || onPhase)))
      exclOk = 1'b0;
  endtask

  task automatic waitDrive();
    int n = 0;
    do begin
      step();
      n++;
    end while (!(onPhase && !blanking) && n < LIMIT);
  endtask

  // trip in drive, then measure fast, slow and blank lengths in ticks
  task automatic offRun(int n, int m, int b, bit slow, bit noise);
    int fc = 0, sc = 0, bc = 0, g = 0;
    offCode = 5'(n); fastCode = 4'(m); blankCode = 2'(b); slowMode = slow;
    waitDrive();
    trip = 1'b1;
    step();
    trip = noise ? 1'($urandom_range(1)) : 1'b0;
    check(fastDecay || slowDecay, "R2 off entered", int'(fastDecay || slowDecay), 1);
    while ((fastDecay || slowDecay) && g < LIMIT) begin
      if (oscTick) begin
        if (fastDecay) fc++;
        else sc++;
      end
      step(); g++;
      trip = noise ? 1'($urandom_range(1)) : 1'b0;
    end
    check(blanking && onPhase, "R6 blank after off", int'(blanking), 1);
    while (blanking && g < LIMIT) begin
      if (oscTick) bc++;
      step(); g++;
      trip = noise ? 1'($urandom_range(1)) : 1'b0;
    end
    trip = 1'b0;
    check(fc + sc == offLenF(n), "R2/R7 off length", fc + sc, offLenF(n));
    check(fc == fastPartF(m, n, slow), slow ? "R5 fast ticks" : "R3/R4 fast ticks",
          fc, fastPartF(m, n, slow));
    check(bc == blankLenF(b), "R6 blank length", bc, blankLenF(b));
  endtask

  task automatic countBlank(output int bc);
    int g = 0;
    bc = 0;
    while (blanking && g < LIMIT) begin
      if (oscTick) bc++;
      step(); g++;
    end
  endtask

  initial begin
    int bc;
    void'($urandom(1234));
    offCode = 5'd3;
    repeat (3) step();
    check(!(onPhase || fastDecay || slowDecay || blanking), "R1 reset outputs",
          int'({onPhase, fastDecay, slowDecay, blanking}), 0);
    rstN = 1'b1;
    enable = 1'b1; curCode = 6'd0; trip = 1'b1;
    repeat (3) step();
    check(!(onPhase || fastDecay || slowDecay || blanking), "R1/R9 zero code idle",
          int'({onPhase, fastDecay, slowDecay, blanking}), 0);
    trip = 1'b0;
    curCode = 6'd20;
    step();
    check(blanking && onPhase, "R9 activation blanks first", int'(blanking), 1);

    // directed corners
    offRun(0, 0, 0, 1'b0, 1'b0);
    offRun(31, 15, 3, 1'b0, 1'b0);
    offRun(0, 15, 1, 1'b0, 1'b0);
    offRun(2, 5, 2, 1'b0, 1'b1);
    offRun(4, 1, 2, 1'b1, 1'b1);
    tickDiv = 3;
    offRun(5, 2, 1, 1'b0, 1'b1);

    // R8: phase change during blanking restarts the window
    tickDiv = 1;
    blankCode = 2'd3;
    waitDrive();
    trip = 1'b1; step(); trip = 1'b0;
    while (!blanking) step();
    repeat (5) step();
    phase = ~phase;
    step();
    countBlank(bc);
    check(bc == 12, "R8 blank restart", bc, 12);

    // R8: phase change with a simultaneous trip while driving
    blankCode = 2'd1;
    waitDrive();
    phase = ~phase; trip = 1'b1;
    step();
    trip = 1'b0;
    check(blanking && !fastDecay && !slowDecay, "R8 phase over trip", int'(blanking), 1);
    step();
    countBlank(bc);
    check(bc == 5, "R8 remaining blank ticks", bc, 5);

    // R10: no ticks, off period holds
    waitDrive();
    tickDiv = 1000000;
    trip = 1'b1; step(); trip = 1'b0;
    oscTick = 1'b0;
    repeat (30) begin
      @(negedge clk);
      oscTick = 1'b0;
    end
    check(fastDecay || slowDecay, "R10 off holds without tick", int'(fastDecay || slowDecay), 1);
    tickDiv = 1;

    // R9: disable during the off period
    enable = 1'b0;
    step();
    check(!(onPhase || fastDecay || slowDecay || blanking), "R9 disable clears",
          int'({onPhase, fastDecay, slowDecay, blanking}), 0);
    trip = 1'b1;
    repeat (3) step();
    check(!(onPhase || fastDecay || slowDecay || blanking), "R9 trip ignored when off",
          int'({onPhase, fastDecay, slowDecay, blanking}), 0);
    trip = 1'b0;
    enable = 1'b1;
    step();
    check(blanking && onPhase, "R9 reactivate blanks", int'(blanking), 1);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      tickDiv = $urandom_range(3, 1);
      offRun($urandom_range(31), $urandom_range(15), $urandom_range(3),
             1'($urandom_range(3) == 0), 1'b1);
    end

    check(exclOk, "R11 output exclusivity", int'(exclOk), 1);
    finishRun();
  end
endmodule